// File: doc/BRIEF.md
# Double Data Rate Input Capture Register

This block samples a data bus on both edges of a capture clock and hands the two samples to core logic on two parallel outputs. One output takes the sample made on the rising edge of the primary clock. The other takes the sample made on the opposite edge. That opposite edge comes from one of two places. In single-clock operation it is the falling edge of the primary clock. In dual-clock operation it is the rising edge of a second clock that runs in antiphase with the first. Each clock input can be inverted by parameter, which moves its sampling instant by half a period.

A shared clock enable gates every capture register. A force control drives the outputs to a constant: all ones when it is configured as a set, all zeros when it is configured as a reset. It can act synchronously or asynchronously, and set and reset cannot both be enabled. An alignment option adds one more register per bit. It moves the opposite-edge sample onto the primary rising edge, so that both outputs change together in the core clock domain.

The capture is free-running. There is no handshake and no back-pressure, because the pad data cannot be stalled, and the core must take both outputs on every primary rising edge on which the enable is high. Every bit of the bus has its own copy of the capture logic, and no bit affects another.

Top module: `ddr_in_capture`

## Requirements
- R1: When `ce_i` is high, `q0_o` takes the value of `din_i` at each rising edge of the primary capture clock. That clock is `clk0_i`, or its inverse when `INV_C0` is 1.
- R2: With `ALIGN` = 0 and `ce_i` high, `q1_o` takes the value of `din_i` at each rising edge of the secondary capture clock. That clock is the inverse of the primary capture clock when `DUAL_CLK` = 0. It is `clk1_i`, or its inverse when `INV_C1` is 1, when `DUAL_CLK` = 1.
- R3: Setting `INV_C0` or `INV_C1` moves the sampling of the matching output to the falling edge of its clock pin. With both set and `clk1_i` the inverse of `clk0_i`, `q0_o` samples on the falling edge of `clk0_i` and `q1_o` samples on its rising edge.
- R4: With `ALIGN` = 1, `q1_o` changes only at primary rising edges. After such an edge it holds the secondary-edge sample taken in the half cycle before that edge. `q0_o` still holds the sample taken at that same rising edge.
- R5: While `ce_i` is low, no capture register changes on any clock edge, so `q0_o` and `q1_o` hold.
- R6: With `SR_SYNC` = 0, asserting the enabled force input drives both outputs to the force value at once, without a clock edge.
- R7: With `SR_SYNC` = 1, the force input takes effect on the next capture edge of each register and has priority over `ce_i`. The force value is all ones for set (`EN_SET` = 1) and all zeros for reset (`EN_RST` = 1).
- R8: Enabling both `EN_SET` and `EN_RST` stops elaboration with an error. A force input whose parameter is 0 has no effect on the outputs.
- R9: Each bit of `din_i` is captured independently into the same bit position of `q0_o` and `q1_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0_i | input | 1 | Primary capture clock |
| clk1_i | input | 1 | Antiphase secondary clock, used only when DUAL_CLK = 1 |
| din_i | input | WIDTH | Double data rate input data |
| ce_i | input | 1 | Clock enable for all capture registers |
| set_i | input | 1 | Force-to-ones request, active when EN_SET = 1 |
| rst_i | input | 1 | Force-to-zeros request, active when EN_RST = 1 |
| q0_o | output | WIDTH | Primary rising-edge sample |
| q1_o | output | WIDTH | Secondary-edge sample, aligned to the primary clock when ALIGN = 1 |

## Verification
The bench drives all 256 pairs of rising-edge and falling-edge nibbles through an aligned single-clock instance and a non-aligned dual-clock instance with both clocks inverted. A design that swapped edges, dropped an inversion, or let the aligned output move at the falling edge would show the wrong nibble at one of the two half-cycle sample points. Clock-enable hold is tested by driving new data across several edges. A register that ignored the enable would take that data. The synchronous reset is checked just before and just after its edge, and the asynchronous set is checked between edges. A force pin whose parameter is off is toggled during the sweep, and any reaction to it would corrupt the sweep results.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

  typedef enum logic [1:0] {
    SR_NONE       = 2'd0,
    SR_FORCE_ONE  = 2'd1,
    SR_FORCE_ZERO = 2'd2
  } sr_kind_e;

  // Decode the two enable parameters into one force kind (set wins only if alone).
  function automatic sr_kind_e sr_kind(input bit en_set, input bit en_rst);
    if (en_set && !en_rst) return SR_FORCE_ONE;
    if (en_rst && !en_set) return SR_FORCE_ZERO;
    return SR_NONE;
  endfunction

endpackage

// File: rtl/ddr_cap_reg.sv
module ddr_cap_reg #(
  parameter bit SR_VAL  = 1'b0,
  parameter bit SR_SYNC = 1'b1
) (
  input  logic clk,
  input  logic ce,
  input  logic sr,
  input  logic d,
  output logic q
);

  generate
    if (SR_SYNC) begin : g_sync
      always_ff @(posedge clk) begin
        if (sr)      q <= SR_VAL;
        else if (ce) q <= d;
      end
      // Synchronous force lands on the next edge regardless of enable.
      p_sr_sync_r7: assert property (@(posedge clk) sr |=> (q == SR_VAL));
    end else begin : g_async
      always_ff @(posedge clk or posedge sr) begin
        if (sr)      q <= SR_VAL;
        else if (ce) q <= d;
      end
      // Asynchronous force is already in place when the next edge arrives.
      p_sr_async_r6: assert property (@(posedge clk) sr |=> (q == SR_VAL));
    end
  endgenerate

  // Disabled enable freezes the register.
  p_hold_ce_low_r5: assert property (@(posedge clk) disable iff (sr)
    (!ce) |=> $stable(q));

endmodule

// File: rtl/ddr_cap_bit.sv
module ddr_cap_bit #(
  parameter bit ALIGN   = 1'b0,
  parameter bit SR_VAL  = 1'b0,
  parameter bit SR_SYNC = 1'b1
) (
  input  logic clk_pri,
  input  logic clk_sec,
  input  logic ce,
  input  logic sr,
  input  logic d,
  output logic q0,
  output logic q1
);

  logic sec_q;

  ddr_cap_reg #(.SR_VAL(SR_VAL), .SR_SYNC(SR_SYNC)) u_pri (
    .clk(clk_pri), .ce(ce), .sr(sr), .d(d), .q(q0)
  );

  ddr_cap_reg #(.SR_VAL(SR_VAL), .SR_SYNC(SR_SYNC)) u_sec (
    .clk(clk_sec), .ce(ce), .sr(sr), .d(d), .q(sec_q)
  );

  generate
    if (ALIGN) begin : g_align
      // Re-time the secondary sample into the primary domain.
      ddr_cap_reg #(.SR_VAL(SR_VAL), .SR_SYNC(SR_SYNC)) u_aln (
        .clk(clk_pri), .ce(ce), .sr(sr), .d(sec_q), .q(q1)
      );
      p_aligned_q1_r4: assert property (@(posedge clk_pri) disable iff (sr)
        ce |=> (q1 == $past(sec_q)));
    end else begin : g_direct
      assign q1 = sec_q;
      p_sec_capture_r2: assert property (@(posedge clk_sec) disable iff (sr)
        ce |=> (q1 == $past(d)));
    end
  endgenerate

  p_pri_capture_r1: assert property (@(posedge clk_pri) disable iff (sr)
    ce |=> (q0 == $past(d)));

endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
  import ddr_cap_pkg::*;
#(
  parameter int WIDTH    = 1,
  parameter bit DUAL_CLK = 1'b0,
  parameter bit INV_C0   = 1'b0,
  parameter bit INV_C1   = 1'b0,
  parameter bit ALIGN    = 1'b0,
  parameter bit EN_SET   = 1'b0,
  parameter bit EN_RST   = 1'b1,
  parameter bit SR_SYNC  = 1'b1
) (
  input  logic             clk0_i,
  input  logic             clk1_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             ce_i,
  input  logic             set_i,
  input  logic             rst_i,
  output logic [WIDTH-1:0] q0_o,
  output logic [WIDTH-1:0] q1_o
);

  localparam sr_kind_e SR_KIND = sr_kind(EN_SET, EN_RST);
  localparam bit       SR_VAL  = (SR_KIND == SR_FORCE_ONE);

  generate
    if (EN_SET && EN_RST) begin : g_sr_conflict
      $error("ddr_in_capture: set and reset cannot both be enabled");
    end
  endgenerate

  logic clk_pri;
  logic clk_sec;
  logic sr_act;

  assign clk_pri = clk0_i ^ INV_C0;

  generate
    if (DUAL_CLK) begin : g_dual
      assign clk_sec = clk1_i ^ INV_C1;
    end else begin : g_single
      assign clk_sec = ~clk_pri;
    end
  endgenerate

  always_comb begin
    case (SR_KIND)
      SR_FORCE_ONE:  sr_act = set_i;
      SR_FORCE_ZERO: sr_act = rst_i;
      default:       sr_act = 1'b0;
    endcase
  end

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      ddr_cap_bit #(.ALIGN(ALIGN), .SR_VAL(SR_VAL), .SR_SYNC(SR_SYNC)) u_bit (
        .clk_pri (clk_pri),
        .clk_sec (clk_sec),
        .ce      (ce_i),
        .sr      (sr_act),
        .d       (din_i[b]),
        .q0      (q0_o[b]),
        .q1      (q1_o[b])
      );
    end
  endgenerate

endmodule

// File: tb/ddr_in_capture_tb_top.sv
module ddr_in_capture_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk0 = 1'b0;
  logic         clk1;
  logic [W-1:0] din = '0;
  logic         ce = 1'b0;
  logic         rst_a = 1'b1;
  logic         set_a = 1'b0;
  logic         set_b = 1'b1;
  logic         rst_b = 1'b0;
  logic [W-1:0] a_q0, a_q1, b_q0, b_q1;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk0 = ~clk0;
  assign clk1 = ~clk0;

  // Aligned, single clock, synchronous reset.
  ddr_in_capture #(.WIDTH(W), .DUAL_CLK(1'b0), .INV_C0(1'b0), .INV_C1(1'b0),
    .ALIGN(1'b1), .EN_SET(1'b0), .EN_RST(1'b1), .SR_SYNC(1'b1)) dut_i (
    .clk0_i(clk0), .clk1_i(clk1), .din_i(din), .ce_i(ce),
    .set_i(set_a), .rst_i(rst_a), .q0_o(a_q0), .q1_o(a_q1));

  // Non-aligned, dual antiphase clocks both inverted, asynchronous set.
  ddr_in_capture #(.WIDTH(W), .DUAL_CLK(1'b1), .INV_C0(1'b1), .INV_C1(1'b1),
    .ALIGN(1'b0), .EN_SET(1'b1), .EN_RST(1'b0), .SR_SYNC(1'b0)) dut_dual_i (
    .clk0_i(clk0), .clk1_i(clk1), .din_i(din), .ce_i(ce),
    .set_i(set_b), .rst_i(rst_b), .q0_o(b_q0), .q1_o(b_q1));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] prev_f;
    // Force phase: sync reset on A, async set on B, across several edges.
    repeat (3) @(posedge clk0);
    #2;
    chk("R7 reset q0", a_q0, 4'h0);
    chk("R7 reset q1", a_q1, 4'h0);
    chk("R6 set q0", b_q0, 4'hF);
    chk("R6 set q1", b_q1, 4'hF);
    rst_a = 1'b0;
    set_b = 1'b0;
    ce = 1'b1;

    // Exhaustive sweep over rising/falling nibble pairs (R9 per-bit independence).
    prev_f = '0;
    @(negedge clk0); #2;
    for (int k = 0; k < 256; k++) begin
      logic [W-1:0] rv;
      logic [W-1:0] fv;
      rv = 4'(k);
      fv = 4'(k >> 4);
      set_a = (k >= 128);   // R8: disabled set pin on A
      rst_b = k[0];         // R8: disabled reset pin on B
      din = rv;
      @(posedge clk0); #2;
      chk("R1 R9 aligned q0", a_q0, rv);
      chk("R2 R3 dual q1 on clk0 rise", b_q1, rv);
      if (k > 0) begin
        chk("R4 aligned q1 prior half", a_q1, prev_f);
        chk("R3 dual q0 held", b_q0, prev_f);
      end
      din = fv;
      @(negedge clk0); #2;
      chk("R2 R3 dual q0 on clk0 fall", b_q0, fv);
      chk("R1 aligned q0 held at fall", a_q0, rv);
      if (k > 0) chk("R4 aligned q1 steady at fall", a_q1, prev_f);
      prev_f = fv;
    end
    chk("R8 set pin ignored", a_q0, 4'hF);
    set_a = 1'b0;
    rst_b = 1'b0;

    // R5: enable low, fresh data across both edges.
    ce = 1'b0;
    for (int j = 0; j < 3; j++) begin
      din = 4'(j * 5);
      @(posedge clk0); #2;
      din = 4'(j * 3 + 1);
      @(negedge clk0); #2;
    end
    chk("R5 hold a_q0", a_q0, 4'hF);
    chk("R5 hold a_q1", a_q1, 4'hF);
    chk("R5 hold b_q0", b_q0, 4'hF);
    chk("R5 hold b_q1", b_q1, 4'hF);

    // R7: synchronous reset waits for an edge and overrides low enable.
    rst_a = 1'b1;
    #1;
    chk("R7 no early reset", a_q0, 4'hF);
    @(posedge clk0); #2;
    chk("R7 sync reset q0", a_q0, 4'h0);
    chk("R7 sync reset q1", a_q1, 4'h0);
    rst_a = 1'b0;

    // R6: asynchronous set between edges.
    ce = 1'b1;
    din = 4'h2;
    @(negedge clk0); #2;
    chk("R3 dual q0 before set", b_q0, 4'h2);
    set_b = 1'b1;
    #1;
    chk("R6 async set q0", b_q0, 4'hF);
    chk("R6 async set q1", b_q1, 4'hF);
    #1;
    set_b = 1'b0;
    din = 4'h9;
    @(posedge clk0); #2;
    chk("R2 dual q1 after set", b_q1, 4'h9);
    chk("R1 aligned q0 after reset", a_q0, 4'h9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule